// File: doc/BRIEF.md
# Hop-by-Hop Circuit Slot Reservation Agent

This block runs once per router. It reads connection-control packets delivered by the packet-switched network and keeps the router's time-slot table up to date. The table has one entry for each pair of slot and output port. An entry is either empty or names the input port that owns that output during that slot. Every control packet names an input and output port pair, a slot number, a count of hops still to travel in its current direction, and a count of hops already travelled.

A set-up request claims its slot on the requested output if the slot is free and passes itself on with the next slot. If the slot is taken, the request turns back as an upstream teardown. That teardown releases the claims made by earlier routers, and each of those claims sits one slot earlier than the one after it. A set-up that has reached its endpoint comes back to the source as an acknowledgement. Teardowns travelling either way release only entries that belong to the port pair they name.

The agent handles one packet at a time. It reads, checks and writes the table before it accepts the next packet, so packets that interleave can never leave an entry half updated.

Top module: `resv_agent`

## Requirements
- R1: After reset every table entry is empty, `out_valid` is low and `in_ready` is high.
- R2: A packet is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the out_* ports for exactly one cycle, two clock edges after acceptance. `in_ready` is low for the cycle that follows acceptance.
- R3: A set-up (kind 0) with a non-zero remaining count whose entry (slot, output port) is empty writes the input port into that entry. It emits kind 0 with slot+1 mod SLOTS, remaining-1 and travelled+1, and both ports unchanged.
- R4: A set-up whose entry is already occupied leaves the table unchanged. It emits an upstream teardown (kind 1) with slot-1 mod SLOTS, remaining set to the incoming travelled count, and travelled set to 0.
- R5: A set-up whose remaining count is 0 has reached its endpoint. It leaves the table unchanged and emits an acknowledgement (kind 3) with the same slot, remaining set to the incoming travelled count, and travelled set to 0.
- R6: An upstream teardown (kind 1) empties its entry when that entry is owned by the packet's input port. If its remaining count is non-zero it emits kind 1 with slot-1 mod SLOTS, remaining-1 and travelled+1. Otherwise it emits nothing.
- R7: A downstream teardown (kind 2) follows the same ownership rule. If its remaining count is non-zero it emits kind 2 with slot+1 mod SLOTS, remaining-1 and travelled+1. Otherwise it emits nothing.
- R8: A teardown whose input port differs from the entry's owner leaves that entry occupied.
- R9: An acknowledgement (kind 3) never touches the table. If its remaining count is non-zero it is passed on with the same slot, remaining-1 and travelled+1. Otherwise it is absorbed.
- R10: Slot arithmetic wraps: SLOTS-1 plus one gives 0, and 0 minus one gives SLOTS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Control packet offered |
| in_ready | output | 1 | Agent idle and able to accept |
| in_kind | input | 2 | 0 set-up, 1 upstream teardown, 2 downstream teardown, 3 acknowledgement |
| in_slot | input | 8 | Slot number, below SLOTS |
| in_iport | input | 3 | Input port of this hop |
| in_oport | input | 3 | Output port of this hop, below PORTS |
| in_left | input | 4 | Hops remaining in the direction of travel |
| in_done | input | 4 | Hops travelled so far |
| out_valid | output | 1 | Emitted packet valid, one-cycle pulse |
| out_kind | output | 2 | Kind of emitted packet |
| out_slot | output | 8 | Adjusted slot |
| out_iport | output | 3 | Input port carried on |
| out_oport | output | 3 | Output port carried on |
| out_left | output | 4 | Remaining hop count |
| out_done | output | 4 | Travelled hop count |

## Verification
The checker runs on every cycle. It confirms the stall after each acceptance and that output never appears without an acceptance two edges earlier. It also confirms that each emitted kind carries the correct slot shift relative to the slot accepted: forward for set-ups and downstream teardowns, backward for upstream teardowns, and none for acknowledgements. Which branch a packet takes depends on table contents and ownership, and only the bench scenarios can show that. These scenarios cover claiming, collisions, mismatched and matching releases, and endpoint absorption, checked against a behavioural table in the bench.

// File: rtl/resv_pkg.sv
package resv_pkg;
  parameter int SLOT_W = 8;
  parameter int PORT_W = 3;
  parameter int HOP_W  = 4;

  typedef enum logic [1:0] {
    PK_SETUP = 2'd0,
    PK_TDUP  = 2'd1,
    PK_TDDN  = 2'd2,
    PK_ACK   = 2'd3
  } pk_kind_e;

  typedef struct packed {
    pk_kind_e            kind;
    logic [SLOT_W-1:0]   slot;
    logic [PORT_W-1:0]   iport;
    logic [PORT_W-1:0]   oport;
    logic [HOP_W-1:0]    left;
    logic [HOP_W-1:0]    done;
  } ctl_pkt_t;

  function automatic logic [SLOT_W-1:0] slot_next(input logic [SLOT_W-1:0] s,
                                                  input int unsigned lim);
    if (32'(s) + 32'd1 >= lim) return '0;
    return s + SLOT_W'(1);
  endfunction

  function automatic logic [SLOT_W-1:0] slot_prev(input logic [SLOT_W-1:0] s,
                                                  input int unsigned lim);
    if (s == '0) return SLOT_W'(lim - 32'd1);
    return s - SLOT_W'(1);
  endfunction
endpackage

// File: rtl/slot_table.sv
module slot_table import resv_pkg::*; #(
  parameter int SLOTS = 16,
  parameter int PORTS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [PORT_W-1:0] rd_port,
  output logic              rd_busy,
  output logic [PORT_W-1:0] rd_owner,
  input  logic              wr_en,
  input  logic              wr_set,
  input  logic [PORT_W-1:0] wr_owner
);
  logic              busy_q [SLOTS][PORTS];
  logic [PORT_W-1:0] own_q  [SLOTS][PORTS];

  // read port: compare-select, out-of-range ports read as empty
  always_comb begin
    rd_busy  = 1'b0;
    rd_owner = '0;
    for (int s = 0; s < SLOTS; s++) begin
      for (int p = 0; p < PORTS; p++) begin
        if (rd_slot == SLOT_W'(s) && rd_port == PORT_W'(p)) begin
          rd_busy  = busy_q[s][p];
          rd_owner = own_q[s][p];
        end
      end
    end
  end

  // write goes to the entry currently addressed by the read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++)
        for (int p = 0; p < PORTS; p++)
          busy_q[s][p] <= 1'b0;
    end else if (wr_en) begin
      for (int s = 0; s < SLOTS; s++)
        for (int p = 0; p < PORTS; p++)
          if (rd_slot == SLOT_W'(s) && rd_port == PORT_W'(p))
            busy_q[s][p] <= wr_set;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_set) begin
      for (int s = 0; s < SLOTS; s++)
        for (int p = 0; p < PORTS; p++)
          if (rd_slot == SLOT_W'(s) && rd_port == PORT_W'(p))
            own_q[s][p] <= wr_owner;
    end
  end
endmodule

// File: rtl/resv_decide.sv
module resv_decide import resv_pkg::*; #(
  parameter int SLOTS = 16
) (
  input  ctl_pkt_t          pkt,
  input  logic              busy,
  input  logic [PORT_W-1:0] owner,
  output logic              wr_en,
  output logic              wr_set,
  output logic              emit,
  output ctl_pkt_t          opkt
);
  logic owned;
  assign owned = busy && (owner == pkt.iport);

  always_comb begin
    wr_en  = 1'b0;
    wr_set = 1'b0;
    emit   = 1'b0;
    opkt   = pkt;
    unique case (pkt.kind)
      PK_SETUP: begin
        emit = 1'b1;
        if (pkt.left == '0) begin
          opkt.kind = PK_ACK;
          opkt.left = pkt.done;
          opkt.done = '0;
        end else if (!busy) begin
          wr_en     = 1'b1;
          wr_set    = 1'b1;
          opkt.slot = slot_next(pkt.slot, SLOTS);
          opkt.left = pkt.left - HOP_W'(1);
          opkt.done = pkt.done + HOP_W'(1);
        end else begin
          opkt.kind = PK_TDUP;
          opkt.slot = slot_prev(pkt.slot, SLOTS);
          opkt.left = pkt.done;
          opkt.done = '0;
        end
      end
      PK_TDUP, PK_TDDN: begin
        wr_en     = owned;
        emit      = (pkt.left != '0);
        opkt.slot = (pkt.kind == PK_TDUP) ? slot_prev(pkt.slot, SLOTS)
                                          : slot_next(pkt.slot, SLOTS);
        opkt.left = pkt.left - HOP_W'(1);
        opkt.done = pkt.done + HOP_W'(1);
      end
      default: begin
        emit      = (pkt.left != '0);
        opkt.left = pkt.left - HOP_W'(1);
        opkt.done = pkt.done + HOP_W'(1);
      end
    endcase
  end
endmodule

// File: rtl/resv_agent.sv
module resv_agent import resv_pkg::*; #(
  parameter int SLOTS = 16,
  parameter int PORTS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [SLOT_W-1:0] in_slot,
  input  logic [PORT_W-1:0] in_iport,
  input  logic [PORT_W-1:0] in_oport,
  input  logic [HOP_W-1:0]  in_left,
  input  logic [HOP_W-1:0]  in_done,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [SLOT_W-1:0] out_slot,
  output logic [PORT_W-1:0] out_iport,
  output logic [PORT_W-1:0] out_oport,
  output logic [HOP_W-1:0]  out_left,
  output logic [HOP_W-1:0]  out_done
);
  typedef enum logic {ST_IDLE, ST_EXEC} st_e;

  logic [1:0]        sync_q;
  logic              rst_sync_n;
  st_e               state_q, state_d;
  ctl_pkt_t          pkt_q, out_q, dec_pkt;
  logic              accept, exec;
  logic              tbl_busy, dec_wr, dec_set, dec_emit, out_valid_q;
  logic [PORT_W-1:0] tbl_owner;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign exec     = (state_q == ST_EXEC);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (in_valid) state_d = ST_EXEC;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q     <= ST_IDLE;
      out_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      out_valid_q <= exec && dec_emit;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      pkt_q.kind  <= pk_kind_e'(in_kind);
      pkt_q.slot  <= in_slot;
      pkt_q.iport <= in_iport;
      pkt_q.oport <= in_oport;
      pkt_q.left  <= in_left;
      pkt_q.done  <= in_done;
    end
    if (exec && dec_emit) out_q <= dec_pkt;
  end

  slot_table #(.SLOTS(SLOTS), .PORTS(PORTS)) u_table (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_slot  (pkt_q.slot),
    .rd_port  (pkt_q.oport),
    .rd_busy  (tbl_busy),
    .rd_owner (tbl_owner),
    .wr_en    (exec && dec_wr),
    .wr_set   (dec_set),
    .wr_owner (pkt_q.iport)
  );

  resv_decide #(.SLOTS(SLOTS)) u_decide (
    .pkt    (pkt_q),
    .busy   (tbl_busy),
    .owner  (tbl_owner),
    .wr_en  (dec_wr),
    .wr_set (dec_set),
    .emit   (dec_emit),
    .opkt   (dec_pkt)
  );

  assign out_valid = out_valid_q;
  assign out_kind  = out_q.kind;
  assign out_slot  = out_q.slot;
  assign out_iport = out_q.iport;
  assign out_oport = out_q.oport;
  assign out_left  = out_q.left;
  assign out_done  = out_q.done;
endmodule

// File: rtl/resv_agent_chk.sv
module resv_agent_chk import resv_pkg::*; #(
  parameter int SLOTS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_kind,
  input logic [SLOT_W-1:0] in_slot,
  input logic              out_valid,
  input logic [1:0]        out_kind,
  input logic [SLOT_W-1:0] out_slot
);
  assert_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_out_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_ready, 2));

  assert_setup_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'd0) |->
      ($past(in_kind, 2) == 2'd0 && out_slot == slot_next($past(in_slot, 2), SLOTS)));

  assert_td_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'd1) |->
      out_slot == slot_prev($past(in_slot, 2), SLOTS));

  assert_td_dn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'd2) |->
      ($past(in_kind, 2) == 2'd2 && out_slot == slot_next($past(in_slot, 2), SLOTS)));

  assert_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'd3) |-> out_slot == $past(in_slot, 2));

  assert_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> 32'(out_slot) < SLOTS);
endmodule

bind resv_agent resv_agent_chk #(.SLOTS(SLOTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_kind   (in_kind),
  .in_slot   (in_slot),
  .out_valid (out_valid),
  .out_kind  (out_kind),
  .out_slot  (out_slot)
);

// File: tb/tb_resv_agent.sv
module tb_resv_agent;
  localparam int NS = 16;
  localparam int NP = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, out_valid;
  logic [1:0] in_kind, out_kind;
  logic [7:0] in_slot, out_slot;
  logic [2:0] in_iport, in_oport, out_iport, out_oport;
  logic [3:0] in_left, in_done, out_left, out_done;

  int checks = 0;
  int failures = 0;
  int tbl [NS][NP];

  always #10 clk = ~clk;

  resv_agent #(.SLOTS(NS), .PORTS(NP)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_slot(in_slot), .in_iport(in_iport), .in_oport(in_oport),
    .in_left(in_left), .in_done(in_done), .out_valid(out_valid), .out_kind(out_kind),
    .out_slot(out_slot), .out_iport(out_iport), .out_oport(out_oport),
    .out_left(out_left), .out_done(out_done));

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input int k, input int s, input int ip, input int op,
                      input int l, input int d, input string tag);
    bit e_emit;
    int ek, es, el, ed;
    logic [23:0] exp_v, act_v;
    e_emit = 1'b0; ek = k; es = s; el = l; ed = d;
    case (k)
      0: begin
        e_emit = 1'b1;
        if (l == 0) begin ek = 3; el = d; ed = 0; end
        else if (tbl[s][op] < 0) begin
          tbl[s][op] = ip; es = (s + 1) % NS; el = l - 1; ed = (d + 1) % 16;
        end else begin ek = 1; es = (s + NS - 1) % NS; el = d; ed = 0; end
      end
      1, 2: begin
        if (tbl[s][op] == ip) tbl[s][op] = -1;
        e_emit = (l != 0);
        es = (k == 1) ? (s + NS - 1) % NS : (s + 1) % NS;
        el = l - 1; ed = (d + 1) % 16;
      end
      default: begin e_emit = (l != 0); el = l - 1; ed = (d + 1) % 16; end
    endcase
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_kind = 2'(k); in_slot = 8'(s);
    in_iport = 3'(ip); in_oport = 3'(op); in_left = 4'(l); in_done = 4'(d);
    @(negedge clk);
    in_valid = 1'b0;
    check(!in_ready && !out_valid, "R2 stall", {30'b0, in_ready, out_valid}, 32'h0);
    @(negedge clk);
    check(out_valid == e_emit, {tag, " valid"}, 32'(out_valid), 32'(e_emit));
    if (e_emit) begin
      exp_v = {2'(ek), 8'(es), 3'(ip), 3'(op), 4'(el), 4'(ed)};
      act_v = {out_kind, out_slot, out_iport, out_oport, out_left, out_done};
      check(act_v == exp_v, {tag, " packet"}, 32'(act_v), 32'(exp_v));
    end
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) for (int p = 0; p < NP; p++) tbl[s][p] = -1;
    rst_n = 1'b0; in_valid = 1'b0; in_kind = '0; in_slot = '0;
    in_iport = '0; in_oport = '0; in_left = '0; in_done = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(in_ready && !out_valid, "R1 reset", {30'b0, in_ready, out_valid}, 32'h2);
    send(0, 5, 0, 4, 1, 0, "R1 empty");
    send(0, 3, 1, 2, 2, 0, "R3 claim");
    send(0, 3, 4, 2, 3, 2, "R4 collide");
    send(1, 3, 4, 2, 1, 0, "R8 mismatch");
    send(0, 3, 0, 2, 1, 0, "R8 still held");
    send(1, 3, 1, 2, 0, 1, "R6 release end");
    send(0, 3, 0, 2, 1, 0, "R6 reclaim");
    send(0, 15, 2, 0, 1, 0, "R10 wrap up");
    send(1, 0, 3, 1, 2, 0, "R10 wrap down");
    send(2, 15, 2, 0, 2, 0, "R7 release fwd");
    send(2, 15, 2, 0, 0, 1, "R7 absorb");
    send(0, 15, 1, 0, 1, 0, "R7 reclaim");
    send(0, 7, 1, 3, 0, 5, "R5 endpoint");
    send(0, 7, 2, 3, 1, 0, "R5 untouched");
    send(3, 9, 0, 0, 3, 1, "R9 forward");
    send(3, 9, 0, 0, 0, 2, "R9 absorb");
    send(0, 9, 1, 0, 2, 0, "R9 untouched");
    send(0, 5, 3, 4, 1, 0, "R4 held");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule